// File: doc/BRIEF.md
# Seven-Segment Decoder with Ripple Blanking

This block turns a row of 4-bit BCD digits into active-low seven-segment drive patterns, one pattern per digit, and hides the zeros that carry no information. A fixed decimal point splits the row into an integer part and a fractional part. In the integer part a blanking signal ripples from the most significant digit down towards the point, so leading zeros go dark. In the fractional part a second blanking signal ripples from the least significant digit up towards the point, so trailing zeros go dark. The ripple stops at the first nonzero digit on each side, so a zero that sits between nonzero digits remains lit.

Each digit position has three controls, applied in priority order. Blank forces the digit dark. Lamp test lights every segment. Ripple-blank darkens a zero. The digit on each side of the point never receives a ripple-blank, so a value such as zero still shows as "0.0". The block is purely combinational. The number of digits and the number of fractional digits are parameters. One shared input arms both ripple chains at their far ends. Global blank and lamp-test inputs act on every digit and on every point segment.

Top module: `sseg_chain`

## Requirements
- R1: For a digit value 0 to 9 that is neither blanked nor suppressed, its 7-bit field seg_n[7*i +: 7] carries the glyph active low, with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f and 6 = g. As active-high hex in gfedcba order the glyphs are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F. Digit i sits in digits_i[4*i +: 4], and digit 0 is the least significant.
- R2: A digit value of 10 to 15 drives all seven segments high (dark) when blank_n and lamp_test_n are both high.
- R3: blank_n low drives every segment bit and every dp_n bit high, whatever the other inputs are.
- R4: lamp_test_n low with blank_n high drives every segment bit and every dp_n bit low.
- R5: With ripple_in_n low, lamp_test_n high and blank_n high, an integer-part digit above the ones position is dark when it and every integer digit more significant than it are 0.
- R6: The ones digit, at index FRAC_DIGITS, is never ripple-blanked. A value of 0 there shows the 0 glyph.
- R7: With ripple_in_n low, lamp_test_n high and blank_n high, a fractional digit below index FRAC_DIGITS-1 is dark when it and every less significant fractional digit are 0.
- R8: The fractional digit next to the point, at index FRAC_DIGITS-1, is never ripple-blanked.
- R9: A zero with a nonzero digit on both sides of it within its own half (integer or fractional) stays displayed.
- R10: ripple_in_n high turns off all zero suppression, so every digit value of 0 to 9 shows its glyph.
- R11: With blank_n and lamp_test_n high, dp_n is low only at index FRAC_DIGITS when FRAC_DIGITS > 0. Every other dp_n bit is high.
- R12: A digit value of 10 to 15 counts as significant. It stops the ripple, so a zero beyond it on the same side still shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits_i | input | 4*NUM_DIGITS | BCD digits, digit 0 in the low nibble |
| lamp_test_n | input | 1 | Active-low lamp test for all digits and points |
| blank_n | input | 1 | Active-low blank for all digits and points |
| ripple_in_n | input | 1 | Active-low ripple-blank feed into both chain ends |
| seg_n | output | 7*NUM_DIGITS | Active-low segments, 7 bits per digit, a in bit 0 |
| dp_n | output | NUM_DIGITS | Active-low decimal point segment per digit |

## Verification
The bench sweeps every position over the values 0, 1, 9 and 10. It does this in each control mode, so it covers runs of zeros that stop at a nonzero or an out-of-range code on either side of the point. A design that rippled past the ones digit or past the fractional digit next to the point would darken a lone "0.0". A design that let the ripple continue through a zero that follows a nonzero digit would lose a significant zero. Each position is also walked through all sixteen codes, which catches a wrong glyph, a lit pattern on codes 10 to 15, or an out-of-range code that fails to stop the chain. The blank-over-lamp-test priority and the fixed point position are checked in the same sweeps.

// File: rtl/sseg_pkg.sv
package sseg_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;
    localparam int MAX_DEC = 9;

    // active-low segment vector, bit 0 = a ... bit 6 = g
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        logic lamp_n;
        logic blank_n;
        logic rbi_n;
    } digit_ctl_t;

    typedef enum logic [1:0] {
        SHOW_DARK  = 2'd0,
        SHOW_FULL  = 2'd1,
        SHOW_GLYPH = 2'd2
    } show_mode_e;

    localparam seg_t SEG_DARK = 7'h7F;
    localparam seg_t SEG_FULL = 7'h00;

    function automatic logic is_decimal(bcd_t v);
        return v <= bcd_t'(MAX_DEC);
    endfunction

    function automatic logic is_zero(bcd_t v);
        return v == '0;
    endfunction

    // active-high gfedcba pattern, inverted on return
    function automatic seg_t glyph_n(bcd_t v);
        seg_t lit;
        case (v)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/sseg_digit.sv
module sseg_digit
    import sseg_pkg::*;
(
    input  bcd_t       value_i,
    input  digit_ctl_t ctl_i,
    output seg_t       seg_n_o
);

    show_mode_e mode;
    logic       zero_hide;

    always_comb begin
        zero_hide = !ctl_i.rbi_n && is_zero(value_i);
        if (!ctl_i.blank_n)
            mode = SHOW_DARK;
        else if (!ctl_i.lamp_n)
            mode = SHOW_FULL;
        else if (zero_hide || !is_decimal(value_i))
            mode = SHOW_DARK;
        else
            mode = SHOW_GLYPH;
    end

    always_comb begin
        case (mode)
            SHOW_FULL:  seg_n_o = SEG_FULL;
            SHOW_GLYPH: seg_n_o = glyph_n(value_i);
            default:    seg_n_o = SEG_DARK;
        endcase
    end

endmodule

// File: rtl/sseg_ripple.sv
module sseg_ripple
    import sseg_pkg::*;
#(
    parameter int NUM_DIGITS  = 6,
    parameter int FRAC_DIGITS = 2
) (
    input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    input  logic                        lamp_n,
    input  logic                        ripple_in_n,
    output logic [NUM_DIGITS-1:0]       rbi_n_o
);

    localparam int ONES_IDX = FRAC_DIGITS;
    localparam int NEAR_FRAC = FRAC_DIGITS - 1;

    // leading chain runs downward to the ones digit, trailing chain runs
    // upward to the digit next to the point; both end positions stay shown
    always_comb begin
        logic lead_n;
        logic trail_n;
        rbi_n_o = '1;
        lead_n  = ripple_in_n;
        for (int i = NUM_DIGITS - 1; i > ONES_IDX; i--) begin
            rbi_n_o[i] = lead_n;
            lead_n = !(!lead_n && lamp_n && is_zero(digits_i[BCD_W*i +: BCD_W]));
        end
        trail_n = ripple_in_n;
        for (int i = 0; i < NEAR_FRAC; i++) begin
            rbi_n_o[i] = trail_n;
            trail_n = !(!trail_n && lamp_n && is_zero(digits_i[BCD_W*i +: BCD_W]));
        end
    end

endmodule

// File: rtl/sseg_point.sv
module sseg_point #(
    parameter int NUM_DIGITS  = 6,
    parameter int FRAC_DIGITS = 2
) (
    input  logic                  lamp_n,
    input  logic                  blank_n,
    output logic [NUM_DIGITS-1:0] dp_n_o
);

    localparam bit HAS_POINT = FRAC_DIGITS > 0;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dp
        if (HAS_POINT && i == FRAC_DIGITS) begin : g_at
            assign dp_n_o[i] = !blank_n;
        end else begin : g_off
            assign dp_n_o[i] = !(blank_n && !lamp_n);
        end
    end

endmodule

// File: rtl/sseg_chain.sv
module sseg_chain
    import sseg_pkg::*;
#(
    parameter int NUM_DIGITS  = 6,
    parameter int FRAC_DIGITS = 2
) (
    input  logic [NUM_DIGITS*4-1:0] digits_i,
    input  logic                    lamp_test_n,
    input  logic                    blank_n,
    input  logic                    ripple_in_n,
    output logic [NUM_DIGITS*7-1:0] seg_n,
    output logic [NUM_DIGITS-1:0]   dp_n
);

    logic [NUM_DIGITS-1:0] rbi_n;

    sseg_ripple #(
        .NUM_DIGITS (NUM_DIGITS),
        .FRAC_DIGITS(FRAC_DIGITS)
    ) u_ripple (
        .digits_i   (digits_i),
        .lamp_n     (lamp_test_n),
        .ripple_in_n(ripple_in_n),
        .rbi_n_o    (rbi_n)
    );

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        digit_ctl_t ctl;
        assign ctl = '{lamp_n: lamp_test_n, blank_n: blank_n, rbi_n: rbi_n[i]};

        sseg_digit u_digit (
            .value_i(digits_i[BCD_W*i +: BCD_W]),
            .ctl_i  (ctl),
            .seg_n_o(seg_n[SEG_W*i +: SEG_W])
        );
    end

    sseg_point #(
        .NUM_DIGITS (NUM_DIGITS),
        .FRAC_DIGITS(FRAC_DIGITS)
    ) u_point (
        .lamp_n (lamp_test_n),
        .blank_n(blank_n),
        .dp_n_o (dp_n)
    );

endmodule

// File: rtl/sseg_chain_chk.sv
module sseg_chain_chk #(
    parameter int NUM_DIGITS  = 6,
    parameter int FRAC_DIGITS = 2
) (
    input logic [NUM_DIGITS*4-1:0] digits_i,
    input logic                    lamp_test_n,
    input logic                    blank_n,
    input logic                    ripple_in_n,
    input logic [NUM_DIGITS*7-1:0] seg_n,
    input logic [NUM_DIGITS-1:0]   dp_n
);

    logic known;
    assign known = !$isunknown({digits_i, lamp_test_n, blank_n, ripple_in_n});

    always_comb begin
        if (known) begin
            // R3
            blank_dark_chk: assert (blank_n || (&seg_n && &dp_n));
            // R4
            lamp_full_chk: assert (!blank_n || lamp_test_n || (seg_n == '0 && dp_n == '0));
            // R11
            point_count_chk: assert (!blank_n || !lamp_test_n
                || $countones(~dp_n) == ((FRAC_DIGITS > 0) ? 1 : 0));
            // R6
            ones_shown_chk: assert (!blank_n || !lamp_test_n
                || digits_i[4*FRAC_DIGITS +: 4] > 4'd9
                || seg_n[7*FRAC_DIGITS +: 7] != 7'h7F);
            for (int i = 0; i < NUM_DIGITS; i++) begin
                // R2
                bad_code_dark_chk: assert (!blank_n || !lamp_test_n
                    || digits_i[4*i +: 4] <= 4'd9 || seg_n[7*i +: 7] == 7'h7F);
                // R10
                no_supp_chk: assert (!blank_n || !lamp_test_n || !ripple_in_n
                    || digits_i[4*i +: 4] > 4'd9 || seg_n[7*i +: 7] != 7'h7F);
            end
        end
    end

endmodule

bind sseg_chain sseg_chain_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .FRAC_DIGITS(FRAC_DIGITS)
) u_chk (
    .digits_i   (digits_i),
    .lamp_test_n(lamp_test_n),
    .blank_n    (blank_n),
    .ripple_in_n(ripple_in_n),
    .seg_n      (seg_n),
    .dp_n       (dp_n)
);

// File: tb/sim_sseg_chain.sv
module sim_sseg_chain;

    localparam int ND = 6;
    localparam int FD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [ND*4-1:0] digits;
    logic            lt_n, bl_n, rin_n;
    logic [ND*7-1:0] seg_n;
    logic [ND-1:0]   dp_n;

    int n_cmp = 0;
    int n_bad = 0;

    sseg_chain #(.NUM_DIGITS(ND), .FRAC_DIGITS(FD)) u0 (
        .digits_i   (digits),
        .lamp_test_n(lt_n),
        .blank_n    (bl_n),
        .ripple_in_n(rin_n),
        .seg_n      (seg_n),
        .dp_n       (dp_n)
    );

    function automatic logic [6:0] ref_glyph(logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [ND*7+ND-1:0] model(logic [ND*4-1:0] d,
                                                 logic lt, logic bl, logic rin);
        logic [ND*7-1:0] s;
        logic [ND-1:0]   p, zb;
        logic            run;
        zb  = '0;
        run = !rin;
        for (int i = ND - 1; i > FD; i--) begin
            if (run && lt && d[4*i +: 4] == 4'd0) zb[i] = 1'b1;
            else run = 1'b0;
        end
        run = !rin;
        for (int i = 0; i < FD - 1; i++) begin
            if (run && lt && d[4*i +: 4] == 4'd0) zb[i] = 1'b1;
            else run = 1'b0;
        end
        for (int i = 0; i < ND; i++) begin
            if (!bl)                             s[7*i +: 7] = 7'h7F;
            else if (!lt)                        s[7*i +: 7] = 7'h00;
            else if (zb[i] || d[4*i +: 4] > 9)   s[7*i +: 7] = 7'h7F;
            else                                 s[7*i +: 7] = ~ref_glyph(d[4*i +: 4]);
            p[i] = !(bl && (!lt || (FD > 0 && i == FD)));
        end
        return {s, p};
    endfunction

    task automatic run_case(input logic [ND*4-1:0] d, input logic lt,
                            input logic bl, input logic rin, input string tag);
        logic [ND*7+ND-1:0] exp;
        @(posedge clk);
        digits = d; lt_n = lt; bl_n = bl; rin_n = rin;
        @(negedge clk);
        exp = model(d, lt, bl, rin);
        n_cmp++;
        if ({seg_n, dp_n} !== exp) begin
            n_bad++;
            $display("FAIL %s digits=%h lt=%b bl=%b rin=%b got seg=%h dp=%b expected seg=%h dp=%b",
                     tag, d, lt, bl, rin, seg_n, dp_n, exp[ND*7+ND-1:ND], exp[ND-1:0]);
        end
    endtask

    task automatic grid(input logic lt, input logic bl, input logic rin, input string tag);
        logic [3:0] pick [4];
        logic [ND*4-1:0] d;
        pick[0] = 4'd0; pick[1] = 4'd1; pick[2] = 4'd9; pick[3] = 4'd10;
        for (int code = 0; code < 4096; code++) begin
            for (int k = 0; k < ND; k++) d[4*k +: 4] = pick[(code >> (2*k)) & 3];
            run_case(d, lt, bl, rin, tag);
        end
    endtask

    task automatic walk(input logic rin, input string tag);
        logic [ND*4-1:0] d;
        for (int p = 0; p < ND; p++)
            for (int v = 0; v < 16; v++)
                for (int bgi = 0; bgi < 2; bgi++) begin
                    for (int k = 0; k < ND; k++) d[4*k +: 4] = (bgi == 0) ? 4'd0 : 4'd3;
                    d[4*p +: 4] = 4'(v);
                    run_case(d, 1'b1, 1'b1, rin, tag);
                end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        digits = '0; lt_n = 1'b1; bl_n = 1'b1; rin_n = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state pattern: all zero shows "0.0" with outer digits dark
        run_case(24'h000000, 1'b1, 1'b1, 1'b0, "R5/R6/R7/R8 all-zero");
        // R9: significant zeros inside 1020.05 style values
        run_case(24'h102005, 1'b1, 1'b1, 1'b0, "R9 inner zero");
        run_case(24'h001030, 1'b1, 1'b1, 1'b0, "R9/R7 mixed");
        // R12: out-of-range code stops leading ripple
        run_case(24'hA00000, 1'b1, 1'b1, 1'b0, "R12 code stops ripple");
        // R11 point placement
        run_case(24'h123456, 1'b1, 1'b1, 1'b0, "R11 point");
        // R3 blank beats lamp test
        run_case(24'h888888, 1'b0, 1'b0, 1'b0, "R3 blank over lamp");
        run_case(24'h000000, 1'b0, 1'b1, 1'b0, "R4 lamp test");
        walk(1'b0, "R1/R2/R12 walk");
        walk(1'b1, "R1/R2/R10 walk");
        grid(1'b1, 1'b1, 1'b0, "R5/R6/R7/R8/R9/R12 grid");
        grid(1'b1, 1'b1, 1'b1, "R10 grid");
        grid(1'b0, 1'b1, 1'b0, "R4 grid");
        grid(1'b1, 1'b0, 1'b0, "R3 grid");
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion expected completion");
        summary();
        $finish;
    end

endmodule